// File: doc/BRIEF.md
# HDLC Receive Frame Collector

The collector sits between a 32-byte HDLC receive FIFO and a downstream consumer of whole frames. The FIFO side raises single-cycle events. A pool-full event means 32 bytes are waiting. A message-end event presents a receive status byte and a residual byte count. In extended mode an overflow event can also occur. The collector drains the FIFO into a local frame buffer, one byte per cycle. After each read-out it pulses a release command so the FIFO can reuse the space.

On a message end, the collector first checks the status byte against an exact bit pattern. It then reads the residual bytes and, if the frame is long enough, streams the assembled frame out over a valid/last/ready handshake. Rejected, overlong or empty frames are dropped. Every message end returns the write index to zero, so the next frame starts at the top of the buffer.

Two status formats are supported, selected by `ext_fmt`. The basic format checks only the overflow, CRC-ok and abort bits. The extended format also requires a valid-frame bit, and removes one trailing status byte from the stored length. Deflagging, destuffing and CRC computation happen upstream and are not part of this block.

Top module: `hdlc_rx_collector`

## Requirements
- R1: After reset, `idle` is 1 and `out_valid`, `fifo_rd_en` and `rel_cmd` are 0.
- R2: A pool-full event in the idle state reads exactly 32 bytes from the FIFO (one per cycle with `fifo_rd_en`) and then issues exactly one single-cycle `rel_cmd` pulse.
- R3: In basic mode a message end is accepted only when `rx_stat` bit 5 (CRC ok) is 1 and bits 6 (data overflow) and 4 (abort) are 0. Bits 7 and 3..0 are ignored.
- R4: The residual count is `rx_cnt[4:0]`, where 0 means 32 bytes. Bits 7..5 are ignored.
- R5: A rejected message end reads no bytes, issues one `rel_cmd` pulse, delivers nothing, and resets the write index to zero.
- R6: If the write index plus the incoming count is at least `MAX_LEN`, the event reads no bytes, issues one `rel_cmd` pulse, discards the buffered data and resets the index. A sum of `MAX_LEN`-1 is still accepted.
- R7: In extended mode (`ext_fmt`=1), acceptance also requires `rx_stat` bit 7 (valid frame) to be 1. The delivered length is the stored byte count minus one.
- R8: A resulting frame shorter than one byte is not delivered. After every message end, whether the frame is delivered or dropped, the next frame starts at index zero.
- R9: In extended mode, an overflow event (`rx_ovf`) issues only one `rel_cmd` pulse, with no reads and no delivery. In basic mode `rx_ovf` has no effect.
- R10: A delivered frame is streamed in arrival order. `out_valid` and `out_data` are held while `out_ready` is 0, and `out_last` is 1 on exactly the final byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_fmt | input | 1 | 1 selects the extended status format |
| pool_full | input | 1 | FIFO holds 32 bytes (one-cycle event) |
| msg_end | input | 1 | Frame end reached in FIFO (one-cycle event) |
| rx_ovf | input | 1 | FIFO overflow event, used in extended mode |
| rx_stat | input | 8 | Receive status byte, valid with `msg_end` |
| rx_cnt | input | 8 | Residual byte count register, valid with `msg_end` |
| fifo_rd_en | output | 1 | Pops one byte from the FIFO this cycle |
| fifo_rd_data | input | 8 | FIFO head byte |
| rel_cmd | output | 1 | Release-FIFO command pulse |
| idle | output | 1 | Collector is ready for an event |
| out_valid | output | 1 | Frame byte available |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
The assertions take three things for granted about the inputs. Events are sampled only while `idle` is high. `rx_stat` and `rx_cnt` are valid in the cycle of `msg_end`. `fifo_rd_data` shows the FIFO head byte whenever `fifo_rd_en` is high. The stimulus keeps within these limits: it waits at a falling edge until `idle` is seen, drives each event for exactly one cycle together with its status and count, changes `ext_fmt` only while the block is idle, and serves FIFO bytes from a model that advances only on cycles where a read was requested.

// File: rtl/rxc_pkg.sv
// Package: shared types and status-byte constants for the receive collector.
// Assumes a status byte with the valid/overflow/CRC/abort bits in the upper nibble.
package rxc_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 6;              // holds 1..32
    localparam int POOL_BYTES = 32;

    localparam logic [7:0] BASIC_MASK = 8'h70;
    localparam logic [7:0] BASIC_WANT = 8'h20;
    localparam logic [7:0] EXT_MASK   = 8'hF0;
    localparam logic [7:0] EXT_WANT   = 8'hA0;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_READ = 2'd1,
        S_REL  = 2'd2,
        S_SEND = 2'd3
    } rxc_state_e;
endpackage

// File: rtl/rxc_status_dec.sv
// Status decoder: judges the message-end status byte and turns the residual
// count field into a byte count. Purely combinational.
// Assumes stat/cnt are only meaningful in the cycle of a message-end event.
module rxc_status_dec
    import rxc_pkg::*;
(
    input  logic              ext_fmt,
    input  logic [7:0]        stat,
    input  logic [7:0]        cnt,
    output logic              accept,
    output logic [CNT_W-1:0]  nbytes
);
    // Exact-pattern acceptance, format chosen by ext_fmt.
    always_comb begin
        if (ext_fmt)
            accept = ((stat & EXT_MASK) == EXT_WANT);
        else
            accept = ((stat & BASIC_MASK) == BASIC_WANT);
    end

    // Residual count: low five bits, zero standing for a full pool.
    always_comb begin
        if (cnt[4:0] == 5'd0)
            nbytes = CNT_W'(POOL_BYTES);
        else
            nbytes = {1'b0, cnt[4:0]};
    end
endmodule

// File: rtl/rxc_frame_store.sv
// Frame store: single write port, asynchronous read port.
// Assumes the controller never writes the address currently being read.
module rxc_frame_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store one received byte per write cycle.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // Present the byte at the streaming pointer.
    assign rdata = mem[raddr];
endmodule

// File: rtl/rxc_ctrl.sv
// Collector controller: sequences FIFO read-out, the release pulse, the
// length/overrun decisions and the frame streaming.
// Assumes events arrive only while idle; priority is msg_end, pool_full, rx_ovf.
module rxc_ctrl
    import rxc_pkg::*;
#(
    parameter int MAX_LEN = 64,
    localparam int IDX_W  = $clog2(MAX_LEN + 1),
    localparam int SUM_W  = IDX_W + 1,
    localparam int AW     = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_fmt,
    input  logic             pool_full,
    input  logic             msg_end,
    input  logic             rx_ovf,
    input  logic             accept,
    input  logic [CNT_W-1:0] nbytes,
    output logic             fifo_rd_en,
    output logic             rel_cmd,
    output logic             idle,
    output logic             mem_we,
    output logic [AW-1:0]    mem_waddr,
    output logic [AW-1:0]    mem_raddr,
    output logic             out_valid,
    output logic             out_last,
    input  logic             out_ready
);
    rxc_state_e       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] rem_q;
    logic             eom_q;
    logic [IDX_W-1:0] len_q;
    logic [IDX_W-1:0] rptr_q;

    logic [SUM_W-1:0] need_me;
    logic [SUM_W-1:0] need_pf;
    logic             over_me;
    logic             over_pf;
    logic [IDX_W-1:0] strip;
    logic             has_frame;

    // Overrun tests for both event kinds.
    always_comb begin
        need_me = SUM_W'(idx_q) + SUM_W'(nbytes);
        need_pf = SUM_W'(idx_q) + SUM_W'(POOL_BYTES);
        over_me = (need_me >= SUM_W'(MAX_LEN));
        over_pf = (need_pf >= SUM_W'(MAX_LEN));
    end

    // Trailing status byte removal and the minimum-length test.
    always_comb begin
        strip     = IDX_W'(ext_fmt);
        has_frame = (idx_q > strip);
    end

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
            rem_q   <= '0;
            eom_q   <= 1'b0;
            len_q   <= '0;
            rptr_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (msg_end) begin
                        if (!accept || over_me) begin
                            idx_q   <= '0;
                            eom_q   <= 1'b0;
                            state_q <= S_REL;
                        end else begin
                            rem_q   <= nbytes;
                            eom_q   <= 1'b1;
                            state_q <= S_READ;
                        end
                    end else if (pool_full) begin
                        eom_q <= 1'b0;
                        if (over_pf) begin
                            idx_q   <= '0;
                            state_q <= S_REL;
                        end else begin
                            rem_q   <= CNT_W'(POOL_BYTES);
                            state_q <= S_READ;
                        end
                    end else if (rx_ovf && ext_fmt) begin
                        eom_q   <= 1'b0;
                        state_q <= S_REL;
                    end
                end
                S_READ: begin
                    idx_q <= idx_q + 1'b1;
                    rem_q <= rem_q - 1'b1;
                    if (rem_q == CNT_W'(1))
                        state_q <= S_REL;
                end
                S_REL: begin
                    if (eom_q && has_frame) begin
                        len_q   <= idx_q - strip;
                        rptr_q  <= '0;
                        state_q <= S_SEND;
                    end else begin
                        if (eom_q)
                            idx_q <= '0;
                        state_q <= S_IDLE;
                    end
                end
                S_SEND: begin
                    if (out_ready) begin
                        if (out_last) begin
                            idx_q   <= '0;
                            state_q <= S_IDLE;
                        end else begin
                            rptr_q <= rptr_q + 1'b1;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from state.
    always_comb begin
        idle       = (state_q == S_IDLE);
        fifo_rd_en = (state_q == S_READ);
        mem_we     = fifo_rd_en;
        rel_cmd    = (state_q == S_REL);
        out_valid  = (state_q == S_SEND);
        out_last   = out_valid && (rptr_q == len_q - 1'b1);
        mem_waddr  = idx_q[AW-1:0];
        mem_raddr  = rptr_q[AW-1:0];
    end

    // R1: nothing is read or streamed while idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!fifo_rd_en && !out_valid && !rel_cmd));

    // R2: the release command is a single-cycle pulse.
    a_r2_release_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rel_cmd |=> !rel_cmd);

    // R5: a rejected status goes straight to release, no read.
    a_r5_reject_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && msg_end && !accept) |=> (rel_cmd && !fifo_rd_en));

    // R6: a read never lands at or past the buffer limit.
    a_r6_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> (idx_q < IDX_W'(MAX_LEN)));

    // R9: overflow events in basic mode leave the collector idle.
    a_r9_basic_ovf_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && rx_ovf && !msg_end && !pool_full && !ext_fmt) |=> idle);

    // R10: a stalled byte is held unchanged.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(mem_raddr) && $stable(out_last)));
endmodule

// File: rtl/hdlc_rx_collector.sv
// HDLC receive frame collector top: wires the status decoder, the controller
// and the frame store. Assumes a FIFO whose head byte is on fifo_rd_data and
// which advances on each cycle with fifo_rd_en high. MAX_LEN must exceed 32.
module hdlc_rx_collector
    import rxc_pkg::*;
#(
    parameter int MAX_LEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_fmt,
    input  logic       pool_full,
    input  logic       msg_end,
    input  logic       rx_ovf,
    input  logic [7:0] rx_stat,
    input  logic [7:0] rx_cnt,
    output logic       fifo_rd_en,
    input  logic [7:0] fifo_rd_data,
    output logic       rel_cmd,
    output logic       idle,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready
);
    localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic             accept;
    logic [CNT_W-1:0] nbytes;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [AW-1:0]    mem_raddr;

    rxc_status_dec u_dec (
        .ext_fmt (ext_fmt),
        .stat    (rx_stat),
        .cnt     (rx_cnt),
        .accept  (accept),
        .nbytes  (nbytes)
    );

    rxc_ctrl #(.MAX_LEN(MAX_LEN)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_fmt    (ext_fmt),
        .pool_full  (pool_full),
        .msg_end    (msg_end),
        .rx_ovf     (rx_ovf),
        .accept     (accept),
        .nbytes     (nbytes),
        .fifo_rd_en (fifo_rd_en),
        .rel_cmd    (rel_cmd),
        .idle       (idle),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_raddr  (mem_raddr),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .out_ready  (out_ready)
    );

    rxc_frame_store #(.DEPTH(MAX_LEN), .DATA_W(BYTE_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (fifo_rd_data),
        .raddr (mem_raddr),
        .rdata (out_data)
    );
endmodule

// File: tb/hdlc_rx_collector_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module hdlc_rx_collector_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_fmt = 1'b0;
    logic       pool_full = 1'b0;
    logic       msg_end = 1'b0;
    logic       rx_ovf = 1'b0;
    logic [7:0] rx_stat = 8'h00;
    logic [7:0] rx_cnt = 8'h00;
    logic       fifo_rd_en;
    logic [7:0] fifo_rd_data;
    logic       rel_cmd;
    logic       idle;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_ready = 1'b1;
    logic       bp_en = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int rd_total = 0;
    int rel_total = 0;
    int cap_total = 0;
    int last_total = 0;
    int last_pos = 0;
    logic [7:0] cap [256];

    always #5 clk = ~clk;

    hdlc_rx_collector u_hdlc_rx_collector (
        .clk(clk), .rst_n(rst_n), .ext_fmt(ext_fmt), .pool_full(pool_full),
        .msg_end(msg_end), .rx_ovf(rx_ovf), .rx_stat(rx_stat), .rx_cnt(rx_cnt),
        .fifo_rd_en(fifo_rd_en), .fifo_rd_data(fifo_rd_data), .rel_cmd(rel_cmd),
        .idle(idle), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    assign fifo_rd_data = pat(rd_total);

    // FIFO model and output monitor.
    always @(posedge clk) begin
        if (rst_n) begin
            if (fifo_rd_en) rd_total <= rd_total + 1;
            if (rel_cmd) rel_total <= rel_total + 1;
            if (out_valid && out_ready) begin
                cap[cap_total & 255] <= out_data;
                cap_total <= cap_total + 1;
                if (out_last) begin
                    last_total <= last_total + 1;
                    last_pos <= cap_total;
                end
            end
        end
    end

    // Consumer back-pressure.
    always @(negedge clk) out_ready <= bp_en ? ~out_ready : 1'b1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!idle) @(negedge clk);
    endtask

    task automatic fire(input bit pf, input bit me, input bit ov,
                        input logic [7:0] st, input logic [7:0] cn);
        wait_idle();
        pool_full = pf; msg_end = me; rx_ovf = ov; rx_stat = st; rx_cnt = cn;
        @(negedge clk);
        pool_full = 0; msg_end = 0; rx_ovf = 0;
        while (!idle) @(negedge clk);
    endtask

    // One message end and a check of reads, releases and delivered frame.
    task automatic frame_case(input string req, input logic [7:0] st,
                              input logic [7:0] cn, input int exp_rd, input int exp_len);
        int r0 = rd_total;
        int l0 = rel_total;
        int c0 = cap_total;
        int k0 = last_total;
        int bad = -1;
        fire(0, 1, 0, st, cn);
        chk(rd_total - r0 == exp_rd, {req, " reads"}, rd_total - r0, exp_rd);
        chk(rel_total - l0 == 1, {req, " release"}, rel_total - l0, 1);
        chk(cap_total - c0 == exp_len, {req, " length"}, cap_total - c0, exp_len);
        if (exp_len > 0) begin
            for (int i = 0; i < exp_len; i++)
                if (bad < 0 && cap[(c0 + i) & 255] != pat(r0 + i)) bad = i;
            chk(bad < 0, {req, " data index"}, bad, -1);
            chk(last_total - k0 == 1 && last_pos == c0 + exp_len - 1,
                {req, " last position"}, last_pos - c0, exp_len - 1);
        end else begin
            chk(last_total == k0, {req, " no frame"}, last_total - k0, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(idle == 1'b1, "R1 idle", int'(idle), 1);
        chk(!out_valid && !fifo_rd_en && !rel_cmd, "R1 quiet outputs",
            int'({out_valid, fifo_rd_en, rel_cmd}), 0);
    endtask

    task automatic t_basic();
        frame_case("R3 R4 R10 basic good", 8'h20, 8'h05, 5, 5);
        frame_case("R3 low status bits ignored", 8'h2F, 8'h03, 3, 3);
        frame_case("R4 zero count is 32", 8'h20, 8'hE0, 32, 32);
        frame_case("R8 one byte frame", 8'h20, 8'h01, 1, 1);
    endtask

    task automatic t_pool();
        int r0 = rd_total;
        int l0 = rel_total;
        fire(1, 0, 0, 8'h00, 8'h00);
        chk(rd_total - r0 == 32, "R2 pool reads", rd_total - r0, 32);
        chk(rel_total - l0 == 1, "R2 pool release", rel_total - l0, 1);
        r0 = rd_total; l0 = rel_total;
        begin
            int c0 = cap_total;
            int bad = -1;
            fire(0, 1, 0, 8'h20, 8'h03);
            chk(cap_total - c0 == 35, "R2 pool+end length", cap_total - c0, 35);
            for (int i = 0; i < 35; i++)
                if (bad < 0 && cap[(c0 + i) & 255] != pat(r0 - 32 + i)) bad = i;
            chk(bad < 0, "R2 pool+end data index", bad, -1);
        end
    endtask

    task automatic t_reject();
        frame_case("R5 overflow bit", 8'h60, 8'h04, 0, 0);
        frame_case("R5 abort bit", 8'h30, 8'h04, 0, 0);
        frame_case("R3 no crc ok", 8'h00, 8'h04, 0, 0);
        frame_case("R5 all bad", 8'h70, 8'h04, 0, 0);
        fire(1, 0, 0, 8'h00, 8'h00);
        frame_case("R5 reject after pool", 8'h30, 8'h02, 0, 0);
        frame_case("R8 fresh after reject", 8'h20, 8'h02, 2, 2);
    endtask

    task automatic t_overrun();
        fire(1, 0, 0, 8'h00, 8'h00);
        frame_case("R6 overrun drop", 8'h20, 8'h00, 0, 0);
        frame_case("R6 fresh after overrun", 8'h20, 8'h04, 4, 4);
        fire(1, 0, 0, 8'h00, 8'h00);
        begin
            int c0 = cap_total;
            fire(0, 1, 0, 8'h20, 8'h1F);
            chk(cap_total - c0 == 63, "R6 limit minus one accepted", cap_total - c0, 63);
        end
    endtask

    task automatic t_ext();
        wait_idle(); ext_fmt = 1'b1;
        frame_case("R7 ext good strips byte", 8'hA0, 8'h04, 4, 3);
        frame_case("R7 ext missing valid bit", 8'h20, 8'h04, 0, 0);
        frame_case("R8 ext empty after strip", 8'hA0, 8'h01, 1, 0);
        wait_idle(); ext_fmt = 1'b0;
    endtask

    task automatic t_ovf();
        int r0; int l0; int c0;
        wait_idle(); ext_fmt = 1'b1;
        r0 = rd_total; l0 = rel_total; c0 = cap_total;
        fire(0, 0, 1, 8'h00, 8'h00);
        chk(rel_total - l0 == 1, "R9 ext ovf release", rel_total - l0, 1);
        chk(rd_total == r0 && cap_total == c0, "R9 ext ovf no read",
            rd_total - r0, 0);
        ext_fmt = 1'b0;
        l0 = rel_total;
        fire(0, 0, 1, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        chk(rel_total == l0 && idle, "R9 basic ovf ignored", rel_total - l0, 0);
    endtask

    task automatic t_backpressure();
        wait_idle(); bp_en = 1'b1;
        frame_case("R10 backpressure", 8'h20, 8'h06, 6, 6);
        wait_idle(); bp_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_pool();
        t_reject();
        t_overrun();
        t_ext();
        t_ovf();
        t_backpressure();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule